// File: doc/BRIEF.md
# CAN Test-Mode Pin Router

This block sits between a CAN protocol core and the two physical bus pins. It holds a 16-bit test register that software reads and writes over a small register bus. The fields of that register pick a diagnostic routing for the transmit pin and the receive path. The transmit pin can carry the core's data, the core's sample-point strobe, a forced dominant level or a forced recessive level. Loopback feeds the core's own transmit output back into its receiver. Silent mode holds the core's data off the bus.

The register accepts writes only while the protocol controller asserts its test-enable line. When that line is low, every writable field returns to its reset value. A read-only bit reports the live level of the receive pin after a two-stage synchronizer. A further flag tells the surrounding controller to use its interface buffers directly. This block only drives that flag and does nothing else with it.

Top module: `canx_testmode_router`

## Requirements
- R1: After reset all writable fields are 0 and the register reads 16'h0080: the transmit pin follows the core, the receiver follows the pin, and loopback, silent and basic are all off.
- R2: The register layout is: bit 7 is the receive monitor, bits 6:5 are the transmit select, bit 4 is loopback, bit 3 is silent and bit 2 is basic. A write with `bus_sel` and `bus_wr` high while `test_en` is high loads bits 6:2, and the new value shows on the next cycle.
- R3: While `test_en` is low, writes have no effect and every writable field is cleared to 0 on the next clock.
- R4: Transmit select 00 puts the core's (possibly silenced) data on `can_tx`, 01 puts `core_sample` on it, 10 drives 0 (dominant) and 11 drives 1 (recessive).
- R5: With loopback set, `core_rx` equals `core_tx`. With loopback clear, `core_rx` equals `can_rx`.
- R6: With silent set and transmit select 00, `can_tx` is 1 whatever `core_tx` is, and the receiver still follows `can_rx` unless loopback is set.
- R7: With silent and loopback both set, `can_tx` stays recessive under select 00 while `core_rx` follows `core_tx`.
- R8: Register bit 7 equals the level `can_rx` had two clock edges earlier, 1 meaning recessive. It reads 1 straight after reset and cannot be written.
- R9: Bits 15:8 and 1:0 always read 0, and writes to them have no effect.
- R10: `basic_mode` equals register bit 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| test_en | input | 1 | Test-enable bit from the controller's control register |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the test register |
| core_tx | input | 1 | Transmit bit from the protocol core |
| core_sample | input | 1 | Sample-point strobe from the protocol core |
| core_rx | output | 1 | Receive bit delivered to the protocol core |
| can_tx | output | 1 | Transmit pin |
| can_rx | input | 1 | Receive pin |
| basic_mode | output | 1 | Flag for direct use of the interface buffers |

## Verification
The hardest case to reach is the receive monitor changing while other things change at the same time. The bench has to show that bit 7 lags the pin by exactly two edges while writes, test-enable drops and mode changes all happen in the same cycles. Directed steps alone rarely produce a pin toggle that lines up with a write and a mode change. So after the directed phases, the bench runs a long phase in which `can_rx`, `core_tx`, `core_sample`, `test_en` and write data all change every cycle. A reference model compares every output on every clock throughout. Directed steps then cover each transmit select crossed with silent and loopback.

// File: rtl/canx_pkg.sv
package canx_pkg;

    localparam int REG_W      = 16;
    localparam int BIT_RXMON  = 7;
    localparam int TXSEL_LO   = 5;
    localparam int TXSEL_W    = 2;
    localparam int BIT_LPBK   = 4;
    localparam int BIT_SILENT = 3;
    localparam int BIT_BASIC  = 2;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [TXSEL_W-1:0] {
        TXS_CORE   = 2'b00,
        TXS_STROBE = 2'b01,
        TXS_DOM    = 2'b10,
        TXS_REC    = 2'b11
    } txsel_e;

    typedef struct packed {
        txsel_e txsel;
        logic   lpbk;
        logic   silent;
        logic   basic;
    } test_cfg_t;

    localparam test_cfg_t CFG_RESET = '{txsel: TXS_CORE, lpbk: 1'b0, silent: 1'b0, basic: 1'b0};

    function automatic test_cfg_t cfg_decode(input logic [REG_W-1:0] w);
        test_cfg_t c;
        c.txsel  = txsel_e'(w[TXSEL_LO +: TXSEL_W]);
        c.lpbk   = w[BIT_LPBK];
        c.silent = w[BIT_SILENT];
        c.basic  = w[BIT_BASIC];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_encode(input test_cfg_t c, input logic rxmon);
        logic [REG_W-1:0] w;
        w = '0;
        w[BIT_RXMON]               = rxmon;
        w[TXSEL_LO +: TXSEL_W]     = c.txsel;
        w[BIT_LPBK]                = c.lpbk;
        w[BIT_SILENT]              = c.silent;
        w[BIT_BASIC]               = c.basic;
        return w;
    endfunction

endpackage

// File: rtl/canx_rx_sync.sv
module canx_rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/canx_test_reg.sv
module canx_test_reg
    import canx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             test_en,
    input  logic             wr_stb,
    input  logic [REG_W-1:0] wdata,
    output test_cfg_t        cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (!test_en) begin
            cfg <= CFG_RESET;
        end else if (wr_stb) begin
            cfg <= cfg_decode(wdata);
        end
    end

    // R2: an accepted write is visible on the next cycle unless test mode dropped
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (test_en && wr_stb) |=> (!$past(test_en) || cfg == cfg_decode($past(wdata))));

    // R3: test-enable low clears every field
    a_r3_clear_when_off: assert property (@(posedge clk) disable iff (rst)
        (!test_en) |=> (cfg == CFG_RESET));
endmodule

// File: rtl/canx_pin_mux.sv
module canx_pin_mux
    import canx_pkg::*;
(
    input  test_cfg_t cfg,
    input  logic      core_tx,
    input  logic      core_sample,
    input  logic      pin_rx,
    output logic      pin_tx,
    output logic      to_core_rx
);
    logic core_data;

    always_comb begin
        core_data = cfg.silent ? 1'b1 : core_tx;
        unique case (cfg.txsel)
            TXS_CORE:   pin_tx = core_data;
            TXS_STROBE: pin_tx = core_sample;
            TXS_DOM:    pin_tx = 1'b0;
            TXS_REC:    pin_tx = 1'b1;
            default:    pin_tx = 1'b1;
        endcase
        to_core_rx = cfg.lpbk ? core_tx : pin_rx;
    end
endmodule

// File: rtl/canx_testmode_router.sv
module canx_testmode_router
    import canx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             test_en,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             core_tx,
    input  logic             core_sample,
    output logic             core_rx,
    output logic             can_tx,
    input  logic             can_rx,
    output logic             basic_mode
);
    test_cfg_t cfg;
    logic      rx_mon;
    logic      wr_stb;

    assign wr_stb = bus_sel && bus_wr;

    canx_test_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .test_en (test_en),
        .wr_stb  (wr_stb),
        .wdata   (bus_wdata),
        .cfg     (cfg)
    );

    canx_rx_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (can_rx),
        .q   (rx_mon)
    );

    canx_pin_mux u_mux (
        .cfg         (cfg),
        .core_tx     (core_tx),
        .core_sample (core_sample),
        .pin_rx      (can_rx),
        .pin_tx      (can_tx),
        .to_core_rx  (core_rx)
    );

    assign bus_rdata  = cfg_encode(cfg, rx_mon);
    assign basic_mode = cfg.basic;

    // cycles since reset, saturating, for the monitor latency check
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)              age <= 2'd0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    // R8: monitor bit lags the pin by two edges
    a_r8_rx_latency: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2) |-> (bus_rdata[BIT_RXMON] == $past(can_rx, 2)));

    // R5: loopback feeds core transmit into core receive
    a_r5_loopback: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[BIT_LPBK]) |-> (core_rx == core_tx));

    // R6: silent with core select keeps the pin recessive
    a_r6_silent_recessive: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[BIT_SILENT] && bus_rdata[TXSEL_LO +: TXSEL_W] == 2'b00) |-> can_tx);

    // R4: forced dominant select drives the pin low
    a_r4_forced_dom: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[TXSEL_LO +: TXSEL_W] == 2'b10) |-> !can_tx);

    // R10: flag tracks register bit
    a_r10_basic_flag: assert property (@(posedge clk) disable iff (rst)
        basic_mode == bus_rdata[BIT_BASIC]);
endmodule

// File: tb/canx_testmode_router_tb.sv
module canx_testmode_router_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        test_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        core_tx = 1'b1;
    logic        core_sample = 1'b0;
    logic        core_rx;
    logic        can_tx;
    logic        can_rx = 1'b1;
    logic        basic_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    canx_testmode_router dut_i (
        .clk(clk), .rst(rst), .test_en(test_en), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_tx(core_tx),
        .core_sample(core_sample), .core_rx(core_rx), .can_tx(can_tx),
        .can_rx(can_rx), .basic_mode(basic_mode)
    );

    // behavioural reference model
    int m_sel, m_lb, m_sil, m_bas;
    int rx_hist[$];
    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0; m_lb = 0; m_sil = 0; m_bas = 0;
            rx_hist = {1, 1};
        end else begin
            if (!test_en) begin
                m_sel = 0; m_lb = 0; m_sil = 0; m_bas = 0;
            end else if (bus_sel && bus_wr) begin
                m_sel = (bus_wdata >> 5) & 3;
                m_lb  = (bus_wdata >> 4) & 1;
                m_sil = (bus_wdata >> 3) & 1;
                m_bas = (bus_wdata >> 2) & 1;
            end
            rx_hist.push_back(int'(can_rx));
            void'(rx_hist.pop_front());
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int data, etx, erx, erd;
        data = m_sil ? 1 : int'(core_tx);
        case (m_sel)
            0: etx = data;
            1: etx = int'(core_sample);
            2: etx = 0;
            default: etx = 1;
        endcase
        erx = m_lb ? int'(core_tx) : int'(can_rx);
        erd = (rx_hist[0] << 7) | (m_sel << 5) | (m_lb << 4) | (m_sil << 3) | (m_bas << 2);
        if (m_sil && m_lb) begin
            chk("R7 can_tx", int'(can_tx), etx);
            chk("R7 core_rx", int'(core_rx), erx);
        end else if (m_sil) begin
            chk("R6 can_tx", int'(can_tx), etx);
            chk("R6 core_rx", int'(core_rx), erx);
        end else begin
            chk("R4 can_tx", int'(can_tx), etx);
            chk("R5 core_rx", int'(core_rx), erx);
        end
        chk("R2/R3 fields", int'(bus_rdata[6:2]), erd[6:2]);
        chk("R8 rx monitor", int'(bus_rdata[7]), erd[7]);
        chk("R9 reserved", int'({bus_rdata[15:8], bus_rdata[1:0]}), 0);
        chk("R10 basic", int'(basic_mode), m_bas);
    endtask

    task automatic step(input bit te, input bit wr, input logic [15:0] wd,
                        input bit ctx, input bit csp, input bit rx);
        @(negedge clk);
        test_en = te; bus_sel = wr; bus_wr = wr; bus_wdata = wd;
        core_tx = ctx; core_sample = csp; can_rx = rx;
        #1;
        compare_all();
    endtask

    task automatic write_cfg(input logic [15:0] wd);
        step(1'b1, 1'b1, wd, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 16'h0, 1'b1, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 rdata after reset", int'(bus_rdata), 16'h0080);
        chk("R1 can_tx follows core", int'(can_tx), int'(core_tx));
        compare_all();

        // R3: write ignored while test mode off
        step(1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
        chk("R3 ignored write", int'(bus_rdata[6:2]), 0);

        // R4..R7: every select crossed with silent/loopback, core data toggling
        for (int s = 0; s < 4; s++) begin
            for (int mode = 0; mode < 4; mode++) begin
                write_cfg(16'((s << 5) | (mode << 3)));
                for (int k = 0; k < 4; k++)
                    step(1'b1, 1'b0, 16'h0, k[0], k[1], ~k[0]);
            end
        end

        // R9: reserved bits written high
        write_cfg(16'hFF03);
        chk("R9 reserved write", int'(bus_rdata), int'({8'h0, bus_rdata[7], 7'h0}));

        // R10: basic flag
        write_cfg(16'h0004);
        chk("R10 basic set", int'(basic_mode), 1);

        // R3: dropping test enable clears fields
        write_cfg(16'h007C);
        step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
        chk("R3 cleared", int'(bus_rdata[6:2]), 0);

        // R8: pin toggles
        for (int i = 0; i < 8; i++)
            step(1'b1, 1'b0, 16'h0, 1'b1, 1'b0, i[1]);

        // mixed phase
        for (int i = 0; i < 3000; i++)
            step(($urandom % 8) != 0, ($urandom % 3) == 0, 16'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule